// File: doc/BRIEF.md
# Multiprocessor Address Match Filter

This block sits on the receive path between a 9-bit serial receiver and the receive FIFO. It supports addressed multi-drop links. Each received frame carries a tag in its top bit (bit 8). A tag of 1 marks the frame as a station address, and a tag of 0 marks it as payload.

When multiprocessor operation is switched on, every address frame is compared with a programmed match byte. The compare covers only the bit positions that a programmed mask selects. A hit opens a gate and a miss closes it. The gate keeps its state until the next address frame, and it decides whether the payload frames in between reach the FIFO. Address frames are never forwarded.

When multiprocessor operation is switched off, the filter is a one-cycle register stage that passes every frame through unchanged. Every forwarded frame appears one clock after the frame is presented.

Top module: `mpf_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and the gate is closed, so payload frames that arrive before any address frame are dropped.
- R2: With `mp_enable` low, every frame presented with `in_valid` high appears on `out_data` one cycle later with `out_valid` high, all 9 bits unchanged, whatever bit 8 is.
- R3: With `mp_enable` high, a frame with bit 8 = 1 is an address frame and never produces `out_valid`.
- R4: An address frame opens the gate when `((in_frame[7:0] ^ match_val) & match_mask) == 0`. Payload frames (bit 8 = 0) that follow are forwarded unchanged one cycle later.
- R5: An address frame that fails that compare closes the gate. Payload frames that follow produce no `out_valid`.
- R6: A mask bit of 0 excludes that address bit from the compare, so an all-zero mask accepts every address.
- R7: The gate state persists across idle cycles and any number of payload frames until the next address frame.
- R8: Any cycle with `mp_enable` low closes the gate. After multiprocessor operation is enabled again, payload is dropped until a matching address arrives.
- R9: A cycle with `in_valid` low produces `out_valid` low in the next cycle.
- R10: `match_val` and `match_mask` are used only when an address frame arrives. Changing them later does not alter the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mp_enable | input | 1 | Enables address filtering |
| match_val | input | 8 | Programmed station address |
| match_mask | input | 8 | A 1 selects an address bit for comparison |
| in_valid | input | 1 | Frame strobe from the receiver |
| in_frame | input | 9 | Received frame; bit 8 is the address tag |
| out_valid | output | 1 | Forwarded frame strobe to the FIFO |
| out_data | output | 9 | Forwarded frame |

## Verification
The assertions assume three things about the inputs. The receiver delivers at most one frame per clock. `mp_enable`, `match_val` and `match_mask` have settled by the clock edge at which a frame is sampled. Frames in filtered mode are genuine 9-bit frames. The stimulus meets all three by changing every input only at the falling edge. It also toggles mode, match and mask only as separate steps of a scripted sequence, and never while a frame is expected in flight. The bench reference model treats the ninth bit purely as a tag, so the pass-through checks also present frames with bit 8 set.

// File: rtl/mpf_pkg.sv
// Package: shared widths and the frame-kind encoding for the address filter.
// Assumes the address tag is the bit directly above the address byte.
package mpf_pkg;
    parameter int unsigned MPF_ADDR_W = 8;
    localparam int unsigned MPF_FRAME_W = MPF_ADDR_W + 1;

    typedef enum logic {
        FR_PAYLOAD = 1'b0,
        FR_ADDRESS = 1'b1
    } frame_kind_e;

    // Decode the tag bit into a frame kind.
    function automatic frame_kind_e kind_of(input logic tag);
        return tag ? FR_ADDRESS : FR_PAYLOAD;
    endfunction
endpackage

// File: rtl/mpf_addr_cmp.sv
// Module: masked address comparator.
// Reports a hit when every address bit selected by the mask equals the
// corresponding match bit. Purely combinational; assumes the inputs are stable.
module mpf_addr_cmp #(
    parameter int unsigned ADDR_W = mpf_pkg::MPF_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] match_val,
    input  logic [ADDR_W-1:0] match_mask,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_miss;

    // One differing-and-selected detector per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_miss[i] = match_mask[i] & (addr[i] ^ match_val[i]);
    end

    // Hit when no selected bit differs.
    always_comb begin
        hit = ~|bit_miss;
    end
endmodule

// File: rtl/mpf_frame_sel.sv
// Module: frame classifier and forwarding decision.
// Splits each valid frame into an address strobe or a forward request,
// according to the mode and the current gate. Combinational.
module mpf_frame_sel #(
    parameter int unsigned ADDR_W = mpf_pkg::MPF_ADDR_W
) (
    input  logic          in_valid,
    input  logic [ADDR_W:0] in_frame,
    input  logic          mp_enable,
    input  logic          gate_open,
    output logic          addr_strobe,
    output logic          fwd
);
    import mpf_pkg::*;

    frame_kind_e kind;

    // Classify the frame by its tag bit.
    always_comb begin
        kind = kind_of(in_frame[ADDR_W]);
    end

    // Decide between address update, forwarding, or drop.
    always_comb begin
        addr_strobe = in_valid && mp_enable && (kind == FR_ADDRESS);
        fwd         = in_valid && (!mp_enable || ((kind == FR_PAYLOAD) && gate_open));
    end
endmodule

// File: rtl/mpf_gate.sv
// Module: persistent receive gate.
// Latches the compare result on each address frame and holds it until the
// next one. Closed by reset and whenever filtering is disabled.
module mpf_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mp_enable,
    input  logic addr_strobe,
    input  logic hit,
    output logic gate_open
);
    // Gate state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_open <= 1'b0;
        end else if (!mp_enable) begin
            gate_open <= 1'b0;
        end else if (addr_strobe) begin
            gate_open <= hit;
        end
    end

    // R8
    mode_off_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_enable |=> !gate_open);
    // R4
    hit_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_enable && addr_strobe && hit) |=> gate_open);
    // R5
    miss_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_enable && addr_strobe && !hit) |=> !gate_open);
    // R7
    gate_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_enable && !addr_strobe) |=> $stable(gate_open));
endmodule

// File: rtl/mpf_filter.sv
// Module: multiprocessor address match filter (top).
// Sits between a 9-bit receiver and the receive FIFO. Forwards frames one
// cycle after they arrive, filtered by a masked address gate when enabled.
// Assumes at most one frame per clock.
module mpf_filter #(
    parameter int unsigned ADDR_W = mpf_pkg::MPF_ADDR_W,
    localparam int unsigned FRAME_W = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mp_enable,
    input  logic [ADDR_W-1:0]  match_val,
    input  logic [ADDR_W-1:0]  match_mask,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_frame,
    output logic               out_valid,
    output logic [FRAME_W-1:0] out_data
);
    logic hit;
    logic gate_open;
    logic addr_strobe;
    logic fwd;

    mpf_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr       (in_frame[ADDR_W-1:0]),
        .match_val  (match_val),
        .match_mask (match_mask),
        .hit        (hit)
    );

    mpf_frame_sel #(.ADDR_W(ADDR_W)) u_sel (
        .in_valid    (in_valid),
        .in_frame    (in_frame),
        .mp_enable   (mp_enable),
        .gate_open   (gate_open),
        .addr_strobe (addr_strobe),
        .fwd         (fwd)
    );

    mpf_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mp_enable   (mp_enable),
        .addr_strobe (addr_strobe),
        .hit         (hit),
        .gate_open   (gate_open)
    );

    // Output strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= fwd;
        end
    end

    // Output data register; loads only on a forwarded frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (fwd) begin
            out_data <= in_frame;
        end
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    addr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mp_enable && in_frame[ADDR_W]) |=> !out_valid);
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mp_enable) |=> (out_valid && out_data == $past(in_frame)));
    // R4
    payload_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mp_enable && !in_frame[ADDR_W] && gate_open)
            |=> (out_valid && out_data == $past(in_frame)));
    // R5
    payload_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mp_enable && !gate_open) |=> !out_valid);
endmodule

// File: tb/mpf_filter_bench.sv
module mpf_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mp_enable = 1'b0;
    logic [7:0] match_val = 8'h00;
    logic [7:0] match_mask = 8'h00;
    logic       in_valid = 1'b0;
    logic [8:0] in_frame = 9'h000;
    logic       out_valid;
    logic [8:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // Reference model state.
    bit         m_gate = 0;
    bit         e_valid = 0;
    logic [8:0] e_data = '0;

    always #5 clk = ~clk;

    mpf_filter u_mpf_filter (
        .clk(clk), .rst_n(rst_n), .mp_enable(mp_enable),
        .match_val(match_val), .match_mask(match_mask),
        .in_valid(in_valid), .in_frame(in_frame),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input bit v, input logic [8:0] f, input string tag);
        in_valid = v;
        in_frame = f;
        @(posedge clk);
        e_valid = 0;
        if (!rst_n) begin
            m_gate = 0;
        end else begin
            if (v) begin
                if (!mp_enable) begin
                    e_valid = 1; e_data = f;
                end else if (f[8]) begin
                    m_gate = (((f[7:0] ^ match_val) & match_mask) == 8'h00);
                end else if (m_gate) begin
                    e_valid = 1; e_data = f;
                end
            end
            if (!mp_enable) m_gate = 0;
        end
        @(negedge clk);
        checks++;
        if (out_valid !== e_valid || (e_valid && out_data !== e_data)) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%03h expected valid=%0b data=%03h",
                     tag, out_valid, out_data, e_valid, e_data);
        end
    endtask

    initial begin : watchdog
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
        finish_run();
    end

    initial begin : stimulus
        @(negedge clk);
        step(0, 9'h000, "R1");
        step(1, 9'h0AA, "R1");
        step(0, 9'h000, "R1");
        rst_n = 1'b1;
        // R1: payload before any address is dropped.
        mp_enable = 1'b1;
        step(1, 9'h011, "R1");
        step(1, 9'h022, "R1");
        // R2: pass-through, including tag-set frames.
        mp_enable = 1'b0;
        for (int i = 0; i < 6; i++) step(1, 9'(i * 83 + 7), "R2");
        step(1, 9'h1FF, "R2");
        step(0, 9'h055, "R9");
        step(1, 9'h100, "R2");
        // R3/R4: matching address opens the gate.
        mp_enable = 1'b1; match_val = 8'h3C; match_mask = 8'hFF;
        step(0, 9'h000, "R9");
        step(1, 9'h13C, "R3");
        for (int i = 0; i < 4; i++) step(1, 9'(i * 29 + 1), "R4");
        // R7: persists across idle gaps.
        step(0, 9'h000, "R7");
        step(0, 9'h000, "R7");
        step(1, 9'h0E1, "R7");
        // R5: non-matching address closes.
        step(1, 9'h13D, "R5");
        step(1, 9'h044, "R5");
        step(0, 9'h000, "R5");
        step(1, 9'h045, "R5");
        // R6: masked bits ignored.
        match_mask = 8'hF0;
        step(1, 9'h135, "R6");
        step(1, 9'h066, "R6");
        match_mask = 8'h00;
        step(1, 9'h1C3, "R6");
        step(1, 9'h077, "R6");
        match_mask = 8'h0F;
        step(1, 9'h1AC, "R6");
        step(1, 9'h078, "R6");
        step(1, 9'h1AD, "R5");
        step(1, 9'h079, "R5");
        // R10: later match changes do not alter the gate.
        match_val = 8'h3C; match_mask = 8'hFF;
        step(1, 9'h13C, "R10");
        match_val = 8'h00;
        step(1, 9'h088, "R10");
        step(1, 9'h089, "R10");
        step(1, 9'h13C, "R10");
        step(1, 9'h08A, "R10");
        // R8: disable closes the gate.
        match_val = 8'h3C;
        step(1, 9'h13C, "R4");
        step(1, 9'h09A, "R4");
        mp_enable = 1'b0;
        step(0, 9'h000, "R8");
        mp_enable = 1'b1;
        step(1, 9'h09B, "R8");
        step(1, 9'h09C, "R8");
        step(1, 9'h13C, "R8");
        step(1, 9'h09D, "R8");
        // Back-to-back addresses.
        step(1, 9'h13C, "R3");
        step(1, 9'h1FF, "R3");
        step(1, 9'h0A0, "R5");
        step(1, 9'h13C, "R4");
        step(1, 9'h0A1, "R4");
        step(0, 9'h000, "R9");
        finish_run();
    end
endmodule